// File: doc/BRIEF.md
# Protection region register file

This block is the software-visible storage for a memory-protection unit that has a set number of regions, from one to sixteen. Each region holds a base address and a combined attribute and size word. A region-number register chooses which region the base and attribute offsets reach. The block also holds a read-only type register that reports the region count and a three-bit control register. The address comparators that use these fields are not part of this block. This block stores the fields, masks off the bits that cannot be written, and returns the stored values on reads.

Requests arrive as a valid/ready stream of 32-bit word accesses with a byte offset. There is one response stream that carries the read data, and writes respond with zero. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request produces exactly one response in the next cycle. A response that is not taken stays held with stable data, and `req_ready` stays low while a response is waiting and `rsp_ready` is low. A base-address write can name its target region directly in its own data. When it does, the same write also moves the region-number register to that region. Any write that names a region the block does not implement is dropped, and `region_err` pulses for one cycle.

Top module: `prot_region_regs`

## Requirements
- R1: After reset, the region number, the control register, and every region's base, attribute and size fields are zero. `rsp_valid` and `region_err` are also low.
- R2: A read of offset 0x90 returns NUM_REGIONS shifted left by 8. Writes to this offset have no effect.
- R3: Offset 0x94 stores only data bits 2:0, which are the enable, the fault-handler enable and the privileged-default enable. It reads back with bits 31:3 as zero.
- R4: A write to the region-number register at offset 0x98 is stored only when its full 32-bit value is below NUM_REGIONS. Otherwise the register keeps its old value.
- R5: A base-address write with data bit 4 set targets the region given by data bits 3:0. In the same access, it loads that index into the region-number register.
- R6: A base-address write with bit 4 clear targets the current region number. The block stores data bits 31:5. A read returns the stored bits 31:5, with bit 4 as zero and the region number in bits 3:0.
- R7: An attribute write at offset 0xa0 stores data[31:16] AND 0x173f as attributes and data[15:0] AND 0xff3f as size. A read returns the attributes in bits 31:16 and the size in bits 15:0.
- R8: The base/attribute pair at 0x9c/0xa0 repeats at +8, +16 and +24 (0xa4/0xa8, 0xac/0xb0, 0xb4/0xb8). Every alias behaves the same as the primary pair.
- R9: A base or attribute write whose target region is at or above NUM_REGIONS changes no region and does not change the region number.
- R10: Any offset not listed reads as zero, and writes to it change nothing.
- R11: `req_ready` is high whenever no response is held or `rsp_ready` is high. Each accepted request gives one response in the next cycle. A response that is not taken stays valid with unchanged data.
- R12: `region_err` is high for exactly the one cycle after an accepted write that R4 or R9 rejects, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset, bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, zero for writes |
| region_err | output | 1 | One-cycle pulse on a rejected region write |

## Verification
A base-address write with its select bit set updates a region entry and the region-number register on the same edge. The target must come from the write data and not from the old region number. The bench triggers this with a region number of 2 or 7 and a write that selects region 6. It then reads back the region number, the new region's base, and an untouched region, and expects each of them independently. The second overlap is a stalled response that meets a new request. The bench holds `rsp_ready` low while it presents a write. It checks that the held read data does not change and that the write lands only in the cycle the stall is released.

// File: rtl/prot_rgn_pkg.sv
package prot_rgn_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BASE_DROP  = 5;
  localparam int unsigned BASE_W     = DATA_W - BASE_DROP;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned FIELD_IDX_W = 4;   // region index field in base writes/reads
  localparam int unsigned CTRL_W     = 3;

  // byte offsets of the register window
  localparam int unsigned OFF_TYPE   = 32'h90;
  localparam int unsigned OFF_CTRL   = 32'h94;
  localparam int unsigned OFF_NUM    = 32'h98;
  localparam int unsigned OFF_BASE   = 32'h9c;
  localparam int unsigned OFF_ATTR   = 32'ha0;
  localparam int unsigned PAIR_COPIES = 4;   // primary pair plus three aliases
  localparam int unsigned PAIR_STEP  = 8;

  localparam logic [HALF_W-1:0] ATTR_KEEP = 16'h173f;
  localparam logic [HALF_W-1:0] SIZE_KEEP = 16'hff3f;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TYPE,
    SEL_CTRL,
    SEL_NUM,
    SEL_BASE,
    SEL_ATTR
  } reg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [HALF_W-1:0] attr;
    logic [HALF_W-1:0] size;
  } region_t;
endpackage

// File: rtl/prot_rgn_decode.sv
module prot_rgn_decode
  import prot_rgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_addr;
  logic              unused_lsb;

  assign word_addr  = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  function automatic logic [WORD_W-1:0] word_of(input int unsigned off);
    logic [31:0] v;
    v = off;
    return v[ADDR_W-1:2];
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if (word_addr == word_of(OFF_TYPE)) sel = SEL_TYPE;
    if (word_addr == word_of(OFF_CTRL)) sel = SEL_CTRL;
    if (word_addr == word_of(OFF_NUM))  sel = SEL_NUM;
    for (int unsigned k = 0; k < PAIR_COPIES; k++) begin
      if (word_addr == word_of(OFF_BASE + k * PAIR_STEP)) sel = SEL_BASE;
      if (word_addr == word_of(OFF_ATTR + k * PAIR_STEP)) sel = SEL_ATTR;
    end
  end
endmodule

// File: rtl/prot_rgn_entry.sv
module prot_rgn_entry
  import prot_rgn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic [DATA_W-1:0] wdata,
  output region_t           q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr_base) q.base <= wdata[DATA_W-1:BASE_DROP];
      if (wr_attr) begin
        q.attr <= wdata[DATA_W-1:HALF_W] & ATTR_KEEP;
        q.size <= wdata[HALF_W-1:0] & SIZE_KEEP;
      end
    end
  end
endmodule

// File: rtl/prot_rgn_rsp.sv
module prot_rgn_rsp
  import prot_rgn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req_ready
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
  import prot_rgn_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              region_err
);
  localparam int unsigned NUM_W   = 8;
  localparam int unsigned IDX_SEL = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [DATA_W-1:0] LIMIT     = DATA_W'(NUM_REGIONS);
  localparam logic [DATA_W-1:0] TYPE_WORD = LIMIT << 8;

  reg_sel_e          sel;
  logic              accept, wr;
  logic              retarget, tgt_ok, num_ok, cur_ok, err_d;
  logic [FIELD_IDX_W-1:0] tgt;
  logic [NUM_W-1:0]  num_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q;
  logic [DATA_W-1:0] rd_data, load_data;
  region_t           rgn [NUM_REGIONS];
  region_t           cur;

  prot_rgn_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  assign accept   = req_valid && req_ready;
  assign wr       = accept && req_write;
  assign retarget = (sel == SEL_BASE) && req_wdata[BASE_DROP-1];
  assign tgt      = retarget ? req_wdata[FIELD_IDX_W-1:0] : num_q[FIELD_IDX_W-1:0];
  assign tgt_ok   = retarget ? (DATA_W'(req_wdata[FIELD_IDX_W-1:0]) < LIMIT)
                             : (DATA_W'(num_q) < LIMIT);
  assign num_ok   = req_wdata < LIMIT;
  assign err_d    = wr && (((sel == SEL_NUM) && !num_ok) ||
                           (((sel == SEL_BASE) || (sel == SEL_ATTR)) && !tgt_ok));

  // per-region storage
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
    logic hit;
    assign hit = wr && tgt_ok && (DATA_W'(tgt) == DATA_W'(i));
    prot_rgn_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (hit && (sel == SEL_BASE)),
      .wr_attr (hit && (sel == SEL_ATTR)),
      .wdata   (req_wdata),
      .q       (rgn[i])
    );
  end

  // region number, control and error pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q  <= '0;
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_d;
      if (wr && (sel == SEL_NUM) && num_ok)
        num_q <= req_wdata[NUM_W-1:0];
      else if (wr && retarget && tgt_ok)
        num_q <= NUM_W'(tgt);
      if (wr && (sel == SEL_CTRL))
        ctrl_q <= req_wdata[CTRL_W-1:0];
    end
  end

  assign region_err = err_q;

  // read path
  assign cur_ok = DATA_W'(num_q) < LIMIT;
  assign cur    = cur_ok ? rgn[num_q[IDX_SEL-1:0]] : '0;

  always_comb begin
    unique case (sel)
      SEL_TYPE: rd_data = TYPE_WORD;
      SEL_CTRL: rd_data = DATA_W'(ctrl_q);
      SEL_NUM:  rd_data = DATA_W'(num_q);
      SEL_BASE: rd_data = cur_ok ? {cur.base, 1'b0, num_q[FIELD_IDX_W-1:0]} : '0;
      SEL_ATTR: rd_data = cur_ok ? {cur.attr, cur.size} : '0;
      default:  rd_data = '0;
    endcase
  end

  assign load_data = req_write ? '0 : rd_data;

  prot_rgn_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (load_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .req_ready (req_ready)
  );
endmodule

// File: rtl/prot_region_regs_chk.sv
module prot_region_regs_chk #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        region_err,
  input logic [7:0]  num_q
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11

  AST_RSP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready)); // R11

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    region_err |-> $past(req_valid && req_ready && req_write)); // R12

  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(num_q) < NUM_REGIONS); // R4

  AST_ERR_KEEPS_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    region_err |-> num_q == $past(num_q)); // R9

  AST_NUM_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready && req_write) |-> $stable(num_q)); // R5
endmodule

bind prot_region_regs prot_region_regs_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .region_err (region_err),
  .num_q      (num_q)
);

// File: tb/tb_prot_region_regs.sv
`timescale 1ns/1ps
module tb_prot_region_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        region_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_region_regs #(.NUM_REGIONS(8), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .region_err(region_err)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h90, 32'h0,        32'h00000800, 1'b0, 4'd2},  // R2 type
    '{1'b1, 8'h90, 32'hffffffff, 32'h0,        1'b0, 4'd2},  // R2 write ignored
    '{1'b0, 8'h90, 32'h0,        32'h00000800, 1'b0, 4'd2},
    '{1'b1, 8'h94, 32'hffffffff, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b0, 8'h94, 32'h0,        32'h00000007, 1'b0, 4'd3},
    '{1'b1, 8'h98, 32'h3,        32'h0,        1'b0, 4'd4},  // R4
    '{1'b0, 8'h98, 32'h0,        32'h3,        1'b0, 4'd4},
    '{1'b1, 8'h9c, 32'h12345678, 32'h0,        1'b1, 4'd9},  // R9 region 8
    '{1'b0, 8'h98, 32'h0,        32'h3,        1'b0, 4'd9},
    '{1'b1, 8'h9c, 32'habcde0e5, 32'h0,        1'b0, 4'd6},  // R6
    '{1'b0, 8'h9c, 32'h0,        32'habcde0e3, 1'b0, 4'd6},
    '{1'b1, 8'ha0, 32'hffffffff, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 8'ha0, 32'h0,        32'h173fff3f, 1'b0, 4'd7},
    '{1'b1, 8'h9c, 32'h00001015, 32'h0,        1'b0, 4'd5},  // R5
    '{1'b0, 8'h98, 32'h0,        32'h5,        1'b0, 4'd5},
    '{1'b0, 8'h9c, 32'h0,        32'h00001005, 1'b0, 4'd5},
    '{1'b0, 8'ha0, 32'h0,        32'h0,        1'b0, 4'd5},
    '{1'b1, 8'h98, 32'h9,        32'h0,        1'b1, 4'd4},  // R4 rejected
    '{1'b0, 8'h98, 32'h0,        32'h5,        1'b0, 4'd4},
    '{1'b1, 8'ha4, 32'h20000013, 32'h0,        1'b0, 4'd8},  // R8 alias 1
    '{1'b0, 8'h9c, 32'h0,        32'h20000003, 1'b0, 4'd8},
    '{1'b0, 8'hb4, 32'h0,        32'h20000003, 1'b0, 4'd8},
    '{1'b1, 8'hb8, 32'h12345678, 32'h0,        1'b0, 4'd8},  // R8 alias 3
    '{1'b0, 8'ha0, 32'h0,        32'h12345638, 1'b0, 4'd8},
    '{1'b0, 8'ha8, 32'h0,        32'h12345638, 1'b0, 4'd8},
    '{1'b1, 8'h40, 32'hffffffff, 32'h0,        1'b0, 4'd10}, // R10
    '{1'b0, 8'h40, 32'h0,        32'h0,        1'b0, 4'd10},
    '{1'b0, 8'hbc, 32'h0,        32'h0,        1'b0, 4'd10},
    '{1'b0, 8'h9c, 32'h0,        32'h20000003, 1'b0, 4'd10},
    '{1'b1, 8'h98, 32'h7,        32'h0,        1'b0, 4'd4},  // R4 top index
    '{1'b0, 8'h98, 32'h0,        32'h7,        1'b0, 4'd4},
    '{1'b1, 8'h98, 32'h8,        32'h0,        1'b1, 4'd4},
    '{1'b0, 8'h98, 32'h0,        32'h7,        1'b0, 4'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    rd = rsp_valid ? rsp_rdata : 32'hdeadbeef;
    e  = region_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R1 region_err", 32'(region_err), 32'h0);
    xfer(1'b0, 8'h98, 0, rd, e); chk("R1 num", rd, 32'h0);
    xfer(1'b0, 8'h94, 0, rd, e); chk("R1 ctrl", rd, 32'h0);
    xfer(1'b0, 8'h9c, 0, rd, e); chk("R1 base", rd, 32'h0);
    xfer(1'b0, 8'ha0, 0, rd, e); chk("R1 attr", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, e);
      chk($sformatf("R%0d row %0d data", VEC[i].rq, i), rd, VEC[i].exp);
      chk($sformatf("R%0d row %0d err", VEC[i].rq, i), 32'(e), 32'(VEC[i].err));
    end

    // R12 pulse lasts one cycle
    xfer(1'b1, 8'h98, 32'h8, rd, e); chk("R12 err high", 32'(e), 32'h1);
    @(negedge clk); chk("R12 err drops", 32'(region_err), 32'h0);

    // R5 same-edge retarget: number 7, write selects region 6
    xfer(1'b1, 8'h9c, 32'h40000016, rd, e); chk("R5 no err", 32'(e), 32'h0);
    xfer(1'b0, 8'h98, 0, rd, e); chk("R5 num moved", rd, 32'h6);
    xfer(1'b0, 8'h9c, 0, rd, e); chk("R5 region6 base", rd, 32'h40000006);
    xfer(1'b1, 8'h98, 32'h7, rd, e);
    xfer(1'b0, 8'h9c, 0, rd, e); chk("R5 region7 untouched", rd, 32'h00000007);

    // R11 back-pressure: stall a read, present a write behind it
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h90;
    @(negedge clk);
    req_write = 1'b1; req_addr = 8'h98; req_wdata = 32'h2;
    chk("R11 rsp valid", 32'(rsp_valid), 32'h1);
    chk("R11 ready low", 32'(req_ready), 32'h0);
    chk("R11 data", rsp_rdata, 32'h800);
    @(negedge clk);
    chk("R11 held valid", 32'(rsp_valid), 32'h1);
    chk("R11 held data", rsp_rdata, 32'h800);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11 write rsp", rsp_rdata, 32'h0);
    xfer(1'b0, 8'h98, 0, rd, e); chk("R11 write landed once", rd, 32'h2);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    chk("R1 rsp after reset", 32'(rsp_valid), 32'h0);
    xfer(1'b0, 8'h98, 0, rd, e); chk("R1 num cleared", rd, 32'h0);
    xfer(1'b0, 8'h94, 0, rd, e); chk("R1 ctrl cleared", rd, 32'h0);
    xfer(1'b1, 8'h98, 32'h3, rd, e);
    xfer(1'b0, 8'h9c, 0, rd, e); chk("R1 region3 base cleared", rd, 32'h3);
    xfer(1'b0, 8'ha0, 0, rd, e); chk("R1 region3 attr cleared", rd, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule